// File: doc/BRIEF.md
# Debug Serial Command Port

This block is a slave-side serial debug port. An external controller drives a slow debug clock, a serial data line and a debug-request line; the port answers on one serial output line. Raising the request puts the port into debug mode. From then on the controller shifts in 8-bit commands, most significant bit first. Each command either reads or writes one entry of a small internal register file. Every 24-bit data word travels most significant bit first as well.

The port tells the controller which phase it has reached by pulling its output line low for a short acknowledge pulse. It pulses once on entering debug mode. After a read command it pulses to say the data is ready. After a write command it pulses to ask for the data, and again once the data is stored. All three debug-side inputs are brought into the system clock domain by a synchronizer chain, and their edges are found there. For that reason the debug clock must run at no more than one eighth of the system clock.

No valid/ready handshake is used. The controller's clock paces the serial stream completely, and there is no back-pressure. The acknowledge pulses take its place: the controller must wait for the relevant pulse before it sends more clocks. If the controller loses its place, it raises the request while in debug mode, waits for the acknowledge, then releases the request. This returns the port to waiting for a command.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset, the output line is high, debug mode is off and every register reads as zero.
- R2: Serial input bits are captured on the falling edge of the debug clock. Output bits change only on its rising edge, so after a read acknowledge the line stays high until the first rising edge.
- R3: A command is 8 bits, MSB first. Bit 7 = 1 means read and 0 means write. Bit 6 = 1 requests leaving debug mode once the command finishes. Bit 5 is ignored. Bits 4..0 select one of 32 registers.
- R4: Outside debug mode, debug clock edges and data bits have no effect. The output line stays high and no acknowledge appears.
- R5: While the port is idle, a high request enters debug mode and produces exactly one acknowledge pulse.
- R6: After a read command, one acknowledge pulse follows. The next 24 rising edges then present the register contents MSB first. After the 24th falling edge the line returns high.
- R7: After a write command, one acknowledge pulse requests data. The next 24 falling edges capture the data MSB first into the addressed register, and a second acknowledge pulse follows.
- R8: Every acknowledge pulse holds the output line low for exactly 2 system clock cycles.
- R9: In debug mode, a rising request aborts any partial command or transfer and produces one acknowledge pulse. Releasing the request then leaves the port waiting for a new command. If a rising request arrives in the same cycle as the final data edge of a write, the abort wins and the register keeps its old value.
- R10: A command with the leave bit set completes normally, including the second acknowledge of a write, and then returns the port to idle. Further serial activity is ignored until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_clk | input | 1 | Debug serial clock from the controller, at most clk/8 |
| dbg_din | input | 1 | Serial command and write data, MSB first |
| dbg_req | input | 1 | Debug request: entry, and resynchronization while in debug mode |
| dbg_dout | output | 1 | Serial read data and low-going acknowledge pulses; idle high |
| dbg_mode | output | 1 | High while the port is in debug mode |

## Verification
The case that needs care is a resynchronizing request edge that lands in the same system cycle as the last falling debug-clock edge of a write's data word. The abort and the register write then compete. The bench provokes this by dropping the debug clock and raising the request on the same system clock edge, so both pass through equal synchronizer depths and reach the controller together. The bench passes the case only if exactly one acknowledge pulse appears and a later read of that register returns its earlier contents, showing that the abort took priority.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  // Command byte layout: bit 7 decides direction, bit 6 asks to leave, low bits address
  localparam int CMD_W        = 8;
  localparam int CMD_RD_BIT   = 7;
  localparam int CMD_EXIT_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WDAT,
    ST_RDAT,
    ST_SYNC
  } dbgp_state_e;

endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk_i,
  input  logic din_i,
  input  logic req_i,
  output logic dclk_rise,
  output logic dclk_fall,
  output logic din_s,
  output logic req_s,
  output logic req_rise,
  output logic req_fall
);

  // STAGES synchronizing flops plus one history flop for edge detection
  logic [STAGES:0]   clk_p;
  logic [STAGES:0]   req_p;
  logic [STAGES-1:0] din_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_p <= '0;
      req_p <= '0;
      din_p <= '0;
    end else begin
      clk_p <= {clk_p[STAGES-1:0], dclk_i};
      req_p <= {req_p[STAGES-1:0], req_i};
      din_p <= {din_p[STAGES-2:0], din_i};
    end
  end

  assign dclk_rise = clk_p[STAGES-1] & ~clk_p[STAGES];
  assign dclk_fall = ~clk_p[STAGES-1] & clk_p[STAGES];
  assign req_rise  = req_p[STAGES-1] & ~req_p[STAGES];
  assign req_fall  = ~req_p[STAGES-1] & req_p[STAGES];
  assign req_s     = req_p[STAGES-1];
  assign din_s     = din_p[STAGES-1];

endmodule

// File: rtl/dbgp_ack.sv
module dbgp_ack #(
  parameter int ACK_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ack_on
);

  localparam int AW = $clog2(ACK_CYCLES + 1);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= AW'(ACK_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - AW'(1);
  end

  assign ack_on = (cnt_q != '0);

  // Pulse-length tracker used only by the checks below
  logic [AW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (ack_on) len_q <= len_q + AW'(1);
    else             len_q <= '0;
  end

  // R8
  ack_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_on) |=> ack_on);

  // R8
  ack_exact_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_on) |-> len_q == AW'(ACK_CYCLES));

endmodule

// File: rtl/dbgp_regs.sv
module dbgp_regs #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [NREG];
  logic [NREG-1:0]   wsel;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_wsel
      assign wsel[g] = wr_en && (wr_addr == ADDR_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wsel[i]) mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R7
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/dbgp_ctrl.sv
module dbgp_ctrl
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk_rise,
  input  logic              dclk_fall,
  input  logic              din_s,
  input  logic              req_s,
  input  logic              req_rise,
  input  logic              req_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ack_start,
  output logic              out_bit,
  output logic              in_debug
);

  localparam int CNT_W = $clog2(DATA_W);

  dbgp_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-2:0]  cmd_sh;
  logic [DATA_W-1:0] dat_sh;
  logic [ADDR_W-1:0] addr_q;
  logic              exit_q;
  logic              out_q;

  logic [CMD_W-1:0]  cmd_next;
  logic [DATA_W-1:0] dat_next;
  logic              busy, abort, enter;
  logic              cmd_done, wdat_done, rdat_done;
  logic              last_cmd_bit, last_dat_bit;
  logic [CMD_EXIT_BIT-1-ADDR_W:0] unused_cmd_bits;

  assign cmd_next        = {cmd_sh, din_s};
  assign dat_next        = {dat_sh[DATA_W-2:0], din_s};
  assign unused_cmd_bits = cmd_next[CMD_EXIT_BIT-1:ADDR_W];

  assign last_cmd_bit = (cnt_q == CNT_W'(CMD_W - 1));
  assign last_dat_bit = (cnt_q == CNT_W'(DATA_W - 1));

  assign busy  = (state_q == ST_CMD) || (state_q == ST_WDAT) || (state_q == ST_RDAT);
  assign abort = busy && req_rise;
  assign enter = (state_q == ST_IDLE) && req_s;

  assign cmd_done  = (state_q == ST_CMD)  && dclk_fall && last_cmd_bit && !abort;
  assign wdat_done = (state_q == ST_WDAT) && dclk_fall && last_dat_bit && !abort;
  assign rdat_done = (state_q == ST_RDAT) && dclk_fall && last_dat_bit && !abort;

  assign rd_addr   = cmd_next[ADDR_W-1:0];
  assign wr_en     = wdat_done;
  assign wr_addr   = addr_q;
  assign wr_data   = dat_next;
  assign ack_start = enter || abort || cmd_done || wdat_done;
  assign out_bit   = out_q;
  assign in_debug  = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_sh  <= '0;
      dat_sh  <= '0;
      addr_q  <= '0;
      exit_q  <= 1'b0;
      out_q   <= 1'b1;
    end else if (abort) begin
      state_q <= ST_SYNC;
      cnt_q   <= '0;
      out_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_s) begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
          end
        end
        ST_SYNC: begin
          if (req_fall) begin
            state_q <= ST_CMD;
            cnt_q   <= '0;
          end
        end
        ST_CMD: begin
          if (dclk_fall) begin
            cmd_sh <= cmd_next[CMD_W-2:0];
            if (last_cmd_bit) begin
              cnt_q  <= '0;
              addr_q <= cmd_next[ADDR_W-1:0];
              exit_q <= cmd_next[CMD_EXIT_BIT];
              if (cmd_next[CMD_RD_BIT]) begin
                state_q <= ST_RDAT;
                dat_sh  <= rd_data;
              end else begin
                state_q <= ST_WDAT;
              end
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_WDAT: begin
          if (dclk_fall) begin
            dat_sh <= dat_next;
            if (last_dat_bit) begin
              cnt_q   <= '0;
              state_q <= exit_q ? ST_IDLE : ST_CMD;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_RDAT: begin
          if (dclk_rise) begin
            out_q  <= dat_sh[DATA_W-1];
            dat_sh <= {dat_sh[DATA_W-2:0], 1'b0};
          end else if (dclk_fall) begin
            if (last_dat_bit) begin
              cnt_q   <= '0;
              out_q   <= 1'b1;
              state_q <= exit_q ? ST_IDLE : ST_CMD;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  cmd_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_CMD |-> cnt_q < CNT_W'(CMD_W));

  // R9
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_SYNC |-> out_q);

  // R6
  rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_done |=> out_q && state_q != ST_RDAT);

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int DATA_W      = 24,
  parameter int ADDR_W      = 5,
  parameter int ACK_CYCLES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_clk,
  input  logic dbg_din,
  input  logic dbg_req,
  output logic dbg_dout,
  output logic dbg_mode
);

  logic              dclk_rise, dclk_fall, din_s;
  logic              req_s, req_rise, req_fall;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en, ack_start, ack_on, out_bit, in_debug;

  dbgp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .dclk_i    (dbg_clk),
    .din_i     (dbg_din),
    .req_i     (dbg_req),
    .dclk_rise (dclk_rise),
    .dclk_fall (dclk_fall),
    .din_s     (din_s),
    .req_s     (req_s),
    .req_rise  (req_rise),
    .req_fall  (req_fall)
  );

  dbgp_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dclk_rise (dclk_rise),
    .dclk_fall (dclk_fall),
    .din_s     (din_s),
    .req_s     (req_s),
    .req_rise  (req_rise),
    .req_fall  (req_fall),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ack_start (ack_start),
    .out_bit   (out_bit),
    .in_debug  (in_debug)
  );

  dbgp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  dbgp_ack #(.ACK_CYCLES(ACK_CYCLES)) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ack_start),
    .ack_on (ack_on)
  );

  assign dbg_dout = out_bit & ~ack_on;
  assign dbg_mode = in_debug;

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_debug && !ack_on |-> dbg_dout);

endmodule

// File: tb/dbg_serial_port_test.sv
module dbg_serial_port_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_clk = 1'b0;
  logic dbg_din = 1'b0;
  logic dbg_req = 1'b0;
  logic dbg_dout, dbg_mode;

  int checks = 0;
  int fails = 0;
  int ack_events = 0;
  int last_width = 0;
  int low_len = 0;
  bit mon_en = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_serial_port uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_clk  (dbg_clk),
    .dbg_din  (dbg_din),
    .dbg_req  (dbg_req),
    .dbg_dout (dbg_dout),
    .dbg_mode (dbg_mode)
  );

  // Acknowledge monitor: measures each low pulse outside read shifting
  always @(negedge clk) begin
    if (dbg_dout === 1'b0) begin
      low_len = low_len + 1;
    end else begin
      if (low_len > 0 && mon_en) begin
        ack_events = ack_events + 1;
        last_width = low_len;
      end
      low_len = 0;
    end
  end

  // address in [28:24], data in [23:0]
  localparam logic [28:0] VEC [6] = '{
    {5'd0,  24'hA5C3F0},
    {5'd31, 24'h800001},
    {5'd7,  24'hFFFFFF},
    {5'd18, 24'h5A5A5A},
    {5'd1,  24'h123456},
    {5'd30, 24'h000001}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic dclk_bit(input logic b);
    dbg_din = b;
    tick(4);
    dbg_clk = 1'b1;
    tick(8);
    dbg_clk = 1'b0;
    tick(8);
  endtask

  task automatic send_cmd(input logic [7:0] cmd);
    for (int i = 7; i >= 0; i--) dclk_bit(cmd[i]);
  endtask

  task automatic wait_ack(input string tag, input int start);
    int t;
    t = 0;
    while (ack_events == start && t < 100) begin
      tick(1);
      t++;
    end
    tick(6);
    chk(tag, ack_events - start, 1);
    chk("R8", last_width, 2);
  endtask

  task automatic enter();
    int s;
    s = ack_events;
    dbg_req = 1'b1;
    wait_ack("R5", s);
    dbg_req = 1'b0;
    tick(10);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [23:0] d);
    int s;
    s = ack_events;
    send_cmd(cmd);
    wait_ack("R7", s);
    s = ack_events;
    for (int i = 23; i >= 0; i--) dclk_bit(d[i]);
    wait_ack("R7", s);
  endtask

  task automatic do_read(input logic [7:0] cmd, output logic [23:0] d);
    int s;
    s = ack_events;
    send_cmd(cmd);
    wait_ack("R6", s);
    mon_en = 1'b0;
    chk("R2", dbg_dout, 1'b1);
    d = '0;
    for (int i = 0; i < 24; i++) begin
      dbg_clk = 1'b1;
      tick(8);
      d = {d[22:0], dbg_dout};
      dbg_clk = 1'b0;
      tick(8);
    end
    chk("R6", dbg_dout, 1'b1);
    tick(2);
    mon_en = 1'b1;
  endtask

  initial begin
    logic [23:0] rd;
    int s;

    // R1: reset state
    tick(5);
    chk("R1", dbg_dout, 1'b1);
    chk("R1", dbg_mode, 1'b0);
    rst_n = 1'b1;
    tick(5);
    chk("R1", dbg_dout, 1'b1);
    chk("R1", dbg_mode, 1'b0);

    // R4: serial activity before entry is ignored
    s = ack_events;
    send_cmd(8'h09);
    dclk_bit(1'b1);
    dclk_bit(1'b0);
    chk("R4", ack_events - s, 0);
    chk("R4", dbg_dout, 1'b1);
    chk("R4", dbg_mode, 1'b0);

    // R5: entry
    enter();
    chk("R5", dbg_mode, 1'b1);

    // R1 / R4: reset register value, stray bits left no partial command
    do_read({3'b100, 5'd9}, rd);
    chk("R1", rd, 24'h0);

    // Table: write all entries, then read each back
    for (int i = 0; i < 6; i++) do_write({3'b000, VEC[i][28:24]}, VEC[i][23:0]);
    for (int i = 0; i < 6; i++) begin
      do_read({3'b100, VEC[i][28:24]}, rd);
      chk("R6 R7", rd, VEC[i][23:0]);
    end

    // R3: bit 5 of the command is ignored
    do_read({3'b101, 5'd31}, rd);
    chk("R3", rd, 24'h800001);

    // R9: resynchronize in the middle of a command
    dclk_bit(1'b1);
    dclk_bit(1'b0);
    dclk_bit(1'b1);
    s = ack_events;
    dbg_req = 1'b1;
    wait_ack("R9", s);
    dbg_req = 1'b0;
    tick(10);
    do_read({3'b100, 5'd0}, rd);
    chk("R9", rd, 24'hA5C3F0);

    // R9: request edge in the same cycle as the final write data edge
    s = ack_events;
    send_cmd({3'b000, 5'd1});
    wait_ack("R7", s);
    for (int i = 23; i >= 1; i--) dclk_bit(1'b1);
    s = ack_events;
    dbg_din = 1'b1;
    tick(4);
    dbg_clk = 1'b1;
    tick(8);
    dbg_clk = 1'b0;
    dbg_req = 1'b1;
    tick(8);
    wait_ack("R9", s);
    dbg_req = 1'b0;
    tick(10);
    chk("R9", dbg_mode, 1'b1);
    do_read({3'b100, 5'd1}, rd);
    chk("R9", rd, 24'h123456);

    // R10: write with the leave bit, then idle activity is ignored
    do_write({3'b010, 5'd4}, 24'h00BEEF);
    tick(10);
    chk("R10", dbg_mode, 1'b0);
    s = ack_events;
    send_cmd({3'b100, 5'd4});
    chk("R10", ack_events - s, 0);
    chk("R10", dbg_dout, 1'b1);
    enter();
    do_read({3'b110, 5'd4}, rd);
    chk("R10", rd, 24'h00BEEF);
    tick(10);
    chk("R10", dbg_mode, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (R1-R10 run): actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule